// File: doc/BRIEF.md
# Clocked Pulse-Logic AND Gate Model

This block is a cycle-level behavioural model of a clocked AND gate built in pulse logic. The gate has two data inputs and a clock input. Each input carries single pulse events, and the gate remembers which data pulses it has seen since its last clock pulse. A clock pulse reads that memory and then clears it. The gate produces an output pulse only when both data pulses arrived before the clock pulse. The model runs on an ordinary system clock. Each pulse event is one strobe, asserted for one system cycle, and a legal cycle carries at most one strobe.

The model is meant to be placed inside larger pulse-circuit models or verification harnesses. Certain pulse arrivals are forbidden:

- a second data pulse on the same input before the gate is clocked;
- two events presented together in one cycle.

Any forbidden arrival moves the gate to a fault state. The fault state is sticky and lasts until a synchronous reset. The current state is visible on a port, so a harness can follow the gate's memory cycle by cycle.

Top module: `pulse_and_cell`

## Requirements
- R1: While `rst_i` is high at a rising edge, the next state is idle. Idle is code 0 on `state_o`. After that edge `pulse_c_o` and `err_o` are low.
- R2: A lone `ev_a_i` strobe in idle moves the state to code 1 (holding a). A lone `ev_b_i` strobe in idle moves it to code 2 (holding b).
- R3: A lone `ev_b_i` strobe in code 1 moves the state to code 3 (holding both). A lone `ev_a_i` strobe in code 2 also moves it to code 3.
- R4: A lone `ev_clk_i` strobe in code 3 raises `pulse_c_o` for exactly the one cycle after the edge that samples it. The same edge returns the state to code 0.
- R5: A lone `ev_clk_i` strobe in codes 0, 1 or 2 returns the state to code 0, drops any held data, and produces no output pulse.
- R6: Three single-strobe cases are forbidden: `ev_a_i` in code 1, `ev_b_i` in code 2, and either data strobe in code 3. Each moves the state to the fault code 4 with no output pulse.
- R7: Two or more strobes in the same cycle move the state to code 4 from any state, with no output pulse.
- R8: Once in code 4, the state stays at 4 and `pulse_c_o` stays low for every input until reset. `err_o` is high exactly when the state is 4.
- R9: A cycle with no strobe leaves the state unchanged and produces no output pulse.
- R10: Reset taken from the fault state returns the gate to idle with `err_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ev_a_i | input | 1 | One-cycle strobe: pulse on data input a |
| ev_b_i | input | 1 | One-cycle strobe: pulse on data input b |
| ev_clk_i | input | 1 | One-cycle strobe: pulse on the gate's clock input |
| pulse_c_o | output | 1 | One-cycle strobe: output pulse c |
| state_o | output | 3 | Current state: 0 idle, 1 a held, 2 b held, 3 both held, 4 fault |
| err_o | output | 1 | High while in the fault state |

## Verification
The properties take for granted that each strobe input is a clean 0 or 1, sampled once per rising edge, and that reset is held for at least one edge before the first event. Nothing is assumed about how many strobes rise together. Multi-strobe cycles are legal stimulus whose outcome is the fault code, so the properties cover them as well. The random stimulus drives mostly single strobes or idle cycles and adds a small share of multi-strobe cycles. It issues resets now and then, and more often once the gate has faulted, so the working states keep being revisited and the sticky fault does not absorb the whole run.

// File: rtl/pac_pkg.sv
package pac_pkg;

   typedef enum logic [2:0] {
      PS_IDLE  = 3'd0,
      PS_A     = 3'd1,
      PS_B     = 3'd2,
      PS_AB    = 3'd3,
      PS_FAULT = 3'd4
   } pstate_e;

   localparam int unsigned PS_W = $bits(pstate_e);

   // index of each event strobe in the packed event vector
   localparam int unsigned EV_A   = 0;
   localparam int unsigned EV_B   = 1;
   localparam int unsigned EV_CLK = 2;
   localparam int unsigned EV_N   = 3;

endpackage

// File: rtl/pac_event_decode.sv
module pac_event_decode #(
   parameter int unsigned N_EV = 3
) (
   input  logic [N_EV-1:0] ev_i,
   output logic            none_o,
   output logic            multi_o
);
   localparam int unsigned CNT_W = $clog2(N_EV + 1);

   logic [CNT_W-1:0] cnt;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < int'(N_EV); i++) begin
         cnt = cnt + CNT_W'(ev_i[i]);
      end
   end

   assign none_o  = (cnt == '0);
   assign multi_o = (cnt > CNT_W'(1));

endmodule

// File: rtl/pac_next_state.sv
module pac_next_state
   import pac_pkg::*;
(
   input  pstate_e          cur_i,
   input  logic [EV_N-1:0]  ev_i,
   input  logic             none_i,
   input  logic             multi_i,
   output pstate_e          nxt_o,
   output logic             fire_o
);
   always_comb begin
      nxt_o  = cur_i;
      fire_o = 1'b0;
      if (cur_i == PS_FAULT || multi_i) begin
         nxt_o = PS_FAULT;
      end else if (none_i) begin
         nxt_o = cur_i;
      end else if (ev_i[EV_CLK]) begin
         fire_o = (cur_i == PS_AB);
         nxt_o  = PS_IDLE;
      end else if (ev_i[EV_A]) begin
         case (cur_i)
            PS_IDLE: nxt_o = PS_A;
            PS_B:    nxt_o = PS_AB;
            default: nxt_o = PS_FAULT;
         endcase
      end else begin
         case (cur_i)
            PS_IDLE: nxt_o = PS_B;
            PS_A:    nxt_o = PS_AB;
            default: nxt_o = PS_FAULT;
         endcase
      end
      // unused codes fall into the fault state
      if (!(cur_i inside {PS_IDLE, PS_A, PS_B, PS_AB, PS_FAULT})) begin
         nxt_o  = PS_FAULT;
         fire_o = 1'b0;
      end
   end

endmodule

// File: rtl/pac_state_reg.sv
module pac_state_reg
   import pac_pkg::*;
#(
   parameter bit REG_PULSE = 1'b1
) (
   input  logic    clk_i,
   input  logic    rst_i,
   input  pstate_e nxt_i,
   input  logic    fire_i,
   output pstate_e state_o,
   output logic    pulse_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i) state_o <= PS_IDLE;
      else       state_o <= nxt_i;
   end

   generate
      if (REG_PULSE) begin : g_reg_pulse
         logic pulse_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) pulse_q <= 1'b0;
            else       pulse_q <= fire_i;
         end
         assign pulse_o = pulse_q;
      end else begin : g_comb_pulse
         assign pulse_o = fire_i & ~rst_i;
      end
   endgenerate

endmodule

// File: rtl/pulse_and_cell.sv
module pulse_and_cell
   import pac_pkg::*;
#(
   parameter bit REG_PULSE = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       ev_a_i,
   input  logic       ev_b_i,
   input  logic       ev_clk_i,
   output logic       pulse_c_o,
   output logic [2:0] state_o,
   output logic       err_o
);
   generate
      if (PS_W != 3) begin : g_bad_width
         $error("state encoding must be three bits wide");
      end
   endgenerate

   logic [EV_N-1:0] ev;
   logic            none, multi, fire;
   pstate_e         cur, nxt;

   assign ev[EV_A]   = ev_a_i;
   assign ev[EV_B]   = ev_b_i;
   assign ev[EV_CLK] = ev_clk_i;

   pac_event_decode #(.N_EV(EV_N)) u_dec (
      .ev_i    (ev),
      .none_o  (none),
      .multi_o (multi)
   );

   pac_next_state u_ns (
      .cur_i   (cur),
      .ev_i    (ev),
      .none_i  (none),
      .multi_i (multi),
      .nxt_o   (nxt),
      .fire_o  (fire)
   );

   pac_state_reg #(.REG_PULSE(REG_PULSE)) u_reg (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .nxt_i   (nxt),
      .fire_i  (fire),
      .state_o (cur),
      .pulse_o (pulse_c_o)
   );

   assign state_o = cur;
   assign err_o   = (cur == PS_FAULT);

endmodule

// File: rtl/pac_checker.sv
module pac_checker (
   input logic       clk_i,
   input logic       rst_i,
   input logic       ev_a_i,
   input logic       ev_b_i,
   input logic       ev_clk_i,
   input logic       pulse_c_o,
   input logic [2:0] state_o,
   input logic       err_o
);
   logic [2:0] evv;
   assign evv = {ev_clk_i, ev_b_i, ev_a_i};

   // R1 / R10: reset always lands in idle without error
   assert_reset_idle_R1: assert property (@(posedge clk_i)
      rst_i |=> (state_o == 3'd0 && !err_o && !pulse_c_o));

   assert_both_fire_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 3'd3 && evv == 3'b100) |=> (pulse_c_o && state_o == 3'd0));

   assert_clk_quiet_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o inside {3'd0, 3'd1, 3'd2} && evv == 3'b100) |=> (!pulse_c_o && state_o == 3'd0));

   assert_forbidden_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      ((state_o == 3'd1 && evv == 3'b001) || (state_o == 3'd2 && evv == 3'b010) ||
       (state_o == 3'd3 && (evv == 3'b001 || evv == 3'b010)))
      |=> (state_o == 3'd4 && !pulse_c_o));

   assert_multi_fault_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      ($countones(evv) > 1) |=> (err_o && !pulse_c_o));

   assert_fault_sticky_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      err_o |=> (err_o && state_o == 3'd4 && !pulse_c_o));

   assert_quiet_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (evv == 3'b000) |=> ($stable(state_o) && !pulse_c_o));

endmodule

bind pulse_and_cell pac_checker u_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .ev_a_i    (ev_a_i),
   .ev_b_i    (ev_b_i),
   .ev_clk_i  (ev_clk_i),
   .pulse_c_o (pulse_c_o),
   .state_o   (state_o),
   .err_o     (err_o)
);

// File: tb/sim_pulse_and_cell.sv
`timescale 1ns/1ps
module sim_pulse_and_cell;
   logic       clk_i = 1'b0;
   logic       rst_i = 1'b1;
   logic       ev_a_i = 1'b0, ev_b_i = 1'b0, ev_clk_i = 1'b0;
   logic       pulse_c_o;
   logic [2:0] state_o;
   logic       err_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic [2:0] exp_st = 3'd0;
   bit done = 1'b0;

   always #10 clk_i = ~clk_i;

   pulse_and_cell u0 (
      .clk_i(clk_i), .rst_i(rst_i), .ev_a_i(ev_a_i), .ev_b_i(ev_b_i),
      .ev_clk_i(ev_clk_i), .pulse_c_o(pulse_c_o), .state_o(state_o), .err_o(err_o)
   );

   // returns {pulse, next state}
   function automatic logic [3:0] model(input logic [2:0] st, input logic a, b, k, r);
      if (r) return {1'b0, 3'd0};
      if (st == 3'd4 || (32'(a) + 32'(b) + 32'(k)) > 1) return {1'b0, 3'd4};
      if (k) return {(st == 3'd3), 3'd0};
      if (a) return (st == 3'd0) ? {1'b0, 3'd1} : (st == 3'd2) ? {1'b0, 3'd3} : {1'b0, 3'd4};
      if (b) return (st == 3'd0) ? {1'b0, 3'd2} : (st == 3'd1) ? {1'b0, 3'd3} : {1'b0, 3'd4};
      return {1'b0, st};
   endfunction

   function automatic string tag_of(input logic [2:0] st, input logic a, b, k, r);
      if (r) return (st == 3'd4) ? "R10" : "R1";
      if ((32'(a) + 32'(b) + 32'(k)) > 1) return "R7";
      if (st == 3'd4) return "R8";
      if (!a && !b && !k) return "R9";
      if (k) return (st == 3'd3) ? "R4" : "R5";
      if ((a && st == 3'd1) || (b && st == 3'd2) || st == 3'd3) return "R6";
      if (st == 3'd0) return "R2";
      return "R3";
   endfunction

   // called just after a falling edge: drive, then check at the next falling edge
   task automatic step(input logic a, b, k, r);
      logic [3:0] m;
      logic [4:0] act, exp;
      string tg;
      m  = model(exp_st, a, b, k, r);
      tg = tag_of(exp_st, a, b, k, r);
      ev_a_i = a; ev_b_i = b; ev_clk_i = k; rst_i = r;
      @(negedge clk_i);
      exp_st = m[2:0];
      exp = {m[3], (m[2:0] == 3'd4), m[2:0]};
      act = {pulse_c_o, err_o, state_o};
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {pulse,err,state} actual=%b expected=%b", tg, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20.0 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20151201));
      @(negedge clk_i);
      step(0,0,0,1); step(0,0,0,1);            // R1
      // R2, R3, R4: a, b, clk -> one output pulse
      step(1,0,0,0); step(0,1,0,0); step(0,0,1,0);
      step(0,0,0,0);                            // R9: pulse gone after one cycle
      // b then a, clk, then a right after: pulse and state 1
      step(0,1,0,0); step(0,0,0,0); step(1,0,0,0); step(0,0,1,0); step(1,0,0,0);
      step(0,0,1,0);                            // R5: held a discarded
      step(0,0,1,0);                            // R5 from idle
      step(0,1,0,0); step(0,0,1,0);             // R5 from state 2
      step(1,0,0,0); step(1,0,0,0);             // R6: repeated a
      step(0,0,1,0); step(1,1,1,0); step(0,0,0,0); // R8 sticky
      step(0,0,0,1);                            // R10
      step(0,1,0,0); step(0,1,0,0); step(0,0,0,1); // R6: repeated b
      step(1,0,0,0); step(0,1,0,0); step(0,1,0,0); step(0,0,0,1); // R6 in state 3
      step(0,0,1,1);                            // R1 reset wins over event
      step(1,0,1,0); step(0,0,0,1);             // R7
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         logic a, b, k, rs;
         r = $urandom % 32;
         a = 0; b = 0; k = 0;
         if (r < 8) begin end
         else if (r < 15) a = 1;
         else if (r < 22) b = 1;
         else if (r < 30) k = 1;
         else begin
            a = 1'($urandom); b = 1'($urandom); k = 1;
            if (!a && !b) a = 1;
         end
         rs = (exp_st == 3'd4) ? (($urandom % 6) == 0) : (($urandom % 200) == 0);
         step(a, b, k, rs);
      end
      finish_run();
   end
endmodule